// File: doc/BRIEF.md
# PWM Audio Sample Controller

This block plays one signed 16-bit audio sample per fixed sample period (8 kHz, which at an 80 MHz system clock is 10000 clocks) on a single-bit pulse-width modulated output. Software writes a sample through a 32-bit register port. The block holds that sample as pending until the current period ends. At the boundary the pending sample becomes the one played for the whole next period, and the ready interrupt rises to ask for the next sample. If software supplies nothing, the last sample keeps playing.

The same register word also carries two amplifier controls: a gain pin and an active-low shutdown pin. These pins are loaded only when a write carries its enable flag, so a plain sample write cannot disturb them. Reads have no side effects. A read returns the pending sample, the readiness flag and the current state of the two amplifier pins.

The sample is turned into offset binary by inverting its sign bit. It is then scaled once per period to a high-time threshold of `floor(offset * CLKS_PER_SAMPLE / 65536)` clocks. The output is high while the period counter is below that threshold.

Top module: `pwm_audio_ctrl`

## Requirements
- R1: After reset `irq` is 1, `shutdownN` is 0, `gainOut` is 0, and `rdData` reads 0x00010000: pending sample 0 and ready set. The active threshold is the one for sample 0, which is CLKS_PER_SAMPLE/2.
- R2: A write (`wrEn`=1) stores `wrData[15:0]` as the pending sample. From the next cycle `rdData[15:0]` returns it, and the ready flag reads 0.
- R3: The period counter runs 0 to CLKS_PER_SAMPLE-1 and wraps. At each wrap the pending sample becomes active and ready is set. `irq` and `rdData[16]` both equal the ready flag at all times.
- R4: Within each period `pwmOut` is 1 for counter values below `floor((sample XOR 0x8000) * CLKS_PER_SAMPLE / 65536)` and 0 otherwise. For example, sample 0x7FFF gives CLKS_PER_SAMPLE-1 high clocks and sample 0x8000 gives none.
- R5: A write with bit 16 set loads `gainOut` from bit 20 and `shutdownN` from bit 21. Those pin values read back on `rdData` bits 20 and 21. Writing 0x00310000 turns the amplifier on with gain, and writing 0x00010000 turns it off.
- R6: A write with bit 16 clear leaves `gainOut` and `shutdownN` unchanged.
- R7: With no new write, every later period repeats the last active sample's high time.
- R8: A write in the same cycle as a period wrap has two effects. The previously pending sample becomes active, and the new sample stays pending with ready low until the following wrap.
- R9: `rdData` bits 31:22 and 19:17 always read 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read value, no read side effects |
| irq | output | 1 | Ready-for-next-sample interrupt |
| pwmOut | output | 1 | Pulse-width modulated audio output |
| gainOut | output | 1 | Amplifier gain select |
| shutdownN | output | 1 | Amplifier shutdown, active low |

## Verification
The critical overlap is a sample write landing on the last clock of a period. In that cycle the boundary tries to set ready and promote the pending sample, while the write tries to clear ready and replace the pending sample. The bench tracks the period position in its own reference model and times a write to hit that exact clock. It then judges three things: `irq` stays low, the following period plays the old pending sample's duty, and only the wrap after that raises `irq` and plays the new sample.

// File: rtl/pwm_audio_pkg.sv
package pwm_audio_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic periodEnd;   // last clock of a sample period
    logic takeSample;  // register write: capture pending sample
    logic takeAmp;     // register write with enable flag: load amp pins
  } ctrlStrobes_t;

  localparam int SAMPLE_W = 16;
  localparam int ENA_BIT  = 16;
  localparam int GAIN_BIT = 20;
  localparam int SHDN_BIT = 21;
endpackage

// File: rtl/pwm_audio_timing.sv
module pwm_audio_timing
  import pwm_audio_pkg::*;
#(
  parameter int CLKS_PER_SAMPLE = 10000,
  localparam int CNT_W = $clog2(CLKS_PER_SAMPLE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic             wrEna,
  output ctrlStrobes_t     strobes,
  output logic [CNT_W-1:0] cnt,
  output logic             ready
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_SAMPLE - 1);

  logic periodEnd;
  assign periodEnd = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (periodEnd) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // A write wins over the boundary: the new sample is still unconsumed.
  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b1;
    end else if (wrEn) begin
      ready <= 1'b0;
    end else if (periodEnd) begin
      ready <= 1'b1;
    end
  end

  always_comb begin
    strobes.periodEnd  = periodEnd;
    strobes.takeSample = wrEn;
    strobes.takeAmp    = wrEn & wrEna;
  end
endmodule

// File: rtl/pwm_audio_datapath.sv
module pwm_audio_datapath
  import pwm_audio_pkg::*;
#(
  parameter int CLKS_PER_SAMPLE = 10000,
  localparam int CNT_W  = $clog2(CLKS_PER_SAMPLE),
  localparam int PROD_W = SAMPLE_W + CNT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strobes,
  input  logic [SAMPLE_W-1:0] newSample,
  input  logic                newGain,
  input  logic                newShdn,
  input  logic [CNT_W-1:0]    cnt,
  output logic [SAMPLE_W-1:0] pendSample,
  output logic                pwmOut,
  output logic                gainOut,
  output logic                shutdownN
);
  logic [SAMPLE_W-1:0] offsetVal;
  logic [PROD_W-1:0]   scaled;
  logic [CNT_W-1:0]    nextThresh;
  logic [CNT_W-1:0]    thresh;

  // signed to offset binary, then scale to clocks in a period
  always_comb begin
    offsetVal  = {~pendSample[SAMPLE_W-1], pendSample[SAMPLE_W-2:0]};
    scaled     = PROD_W'(offsetVal) * PROD_W'(CLKS_PER_SAMPLE);
    nextThresh = scaled[PROD_W-1:SAMPLE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendSample <= '0;
    end else if (strobes.takeSample) begin
      pendSample <= newSample;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thresh <= CNT_W'(CLKS_PER_SAMPLE / 2);
    end else if (strobes.periodEnd) begin
      thresh <= nextThresh;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gainOut   <= 1'b0;
      shutdownN <= 1'b0;
    end else if (strobes.takeAmp) begin
      gainOut   <= newGain;
      shutdownN <= newShdn;
    end
  end

  assign pwmOut = (cnt < thresh);
endmodule

// File: rtl/pwm_audio_ctrl.sv
module pwm_audio_ctrl
  import pwm_audio_pkg::*;
#(
  parameter int CLKS_PER_SAMPLE = 10000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        irq,
  output logic        pwmOut,
  output logic        gainOut,
  output logic        shutdownN
);
  localparam int CNT_W = $clog2(CLKS_PER_SAMPLE);

  ctrlStrobes_t        strobes;
  logic [CNT_W-1:0]    cnt;
  logic                ready;
  logic [SAMPLE_W-1:0] pendSample;
  logic                unusedWrBits;

  assign unusedWrBits = ^{wrData[31:22], wrData[19:17]};

  pwm_audio_timing #(.CLKS_PER_SAMPLE(CLKS_PER_SAMPLE)) u_timing (
    .clk     (clk),
    .rst     (rst),
    .wrEn    (wrEn),
    .wrEna   (wrData[ENA_BIT]),
    .strobes (strobes),
    .cnt     (cnt),
    .ready   (ready)
  );

  pwm_audio_datapath #(.CLKS_PER_SAMPLE(CLKS_PER_SAMPLE)) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .newSample  (wrData[SAMPLE_W-1:0]),
    .newGain    (wrData[GAIN_BIT]),
    .newShdn    (wrData[SHDN_BIT]),
    .cnt        (cnt),
    .pendSample (pendSample),
    .pwmOut     (pwmOut),
    .gainOut    (gainOut),
    .shutdownN  (shutdownN)
  );

  assign irq    = ready;
  assign rdData = {10'b0, shutdownN, gainOut, 3'b0, ready, pendSample};
endmodule

// File: rtl/pwm_audio_chk.sv
module pwm_audio_chk #(
  parameter int CLKS_PER_SAMPLE = 10000,
  localparam int CNT_W = $clog2(CLKS_PER_SAMPLE)
) (
  input logic             clk,
  input logic             rst,
  input logic             wrEn,
  input logic [31:0]      wrData,
  input logic [31:0]      rdData,
  input logic             irq,
  input logic             pwmOut,
  input logic             gainOut,
  input logic             shutdownN,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_SAMPLE - 1);

  AST_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> !irq);  // R2
  AST_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> rdData[15:0] == $past(wrData[15:0]));  // R2
  AST_READY_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(cnt) == LAST);  // R3
  AST_READ_MIRRORS_IRQ: assert property (@(posedge clk) disable iff (rst)
    rdData[16] == irq);  // R3
  AST_AMP_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrData[16]) |=> (gainOut == $past(wrData[20])) && (shutdownN == $past(wrData[21])));  // R5
  AST_AMP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && wrData[16]) |=> $stable(gainOut) && $stable(shutdownN));  // R6
  AST_WRAP_WRITE_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst)
    (wrEn && cnt == LAST) |=> !irq);  // R8
  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (rst)
    rdData[31:22] == 10'd0 && rdData[19:17] == 3'd0);  // R9
  AST_PWM_LOW_AT_LAST: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST) |-> !pwmOut);  // R4
endmodule

bind pwm_audio_ctrl pwm_audio_chk #(.CLKS_PER_SAMPLE(CLKS_PER_SAMPLE)) u_chk (.*);

// File: tb/sim_pwm_audio_ctrl.sv
module sim_pwm_audio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int P = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq, pwmOut, gainOut, shutdownN;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // reference model state
  int refCnt = 0;
  int refThr = P / 2;
  int refPend = 0;
  bit refReady = 1;
  bit refGain = 0;
  bit refShdn = 0;

  pwm_audio_ctrl #(.CLKS_PER_SAMPLE(P)) u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .irq(irq), .pwmOut(pwmOut), .gainOut(gainOut), .shutdownN(shutdownN)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int thrOf(int s);
    longint offs;
    offs = longint'((s ^ 32'h8000) & 32'hFFFF);
    return int'((offs * P) / 65536);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // reference model: behavioural, updated on each rising edge
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      refCnt = 0; refThr = P / 2; refPend = 0;
      refReady = 1; refGain = 0; refShdn = 0;
    end else begin
      if (refCnt == P - 1) begin
        refThr = thrOf(refPend);
        refReady = 1;
        refCnt = 0;
      end else begin
        refCnt++;
      end
      if (wrEn) begin
        refPend = int'(wrData[15:0]);
        refReady = 0;
        if (wrData[16]) begin
          refGain = wrData[20];
          refShdn = wrData[21];
        end
      end
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      logic [31:0] expRd;
      expRd = {10'b0, refShdn, refGain, 3'b0, refReady, refPend[15:0]};
      chk(pwmOut == (refCnt < refThr), "R4 pwmOut", {31'b0, pwmOut}, {31'b0, refCnt < refThr});
      chk(irq == refReady, "R3 irq", {31'b0, irq}, {31'b0, refReady});
      chk(rdData == expRd, "R2 rdData", rdData, expRd);
      chk(gainOut == refGain && shutdownN == refShdn, "R5 amp pins",
          {30'b0, shutdownN, gainOut}, {30'b0, refShdn, refGain});
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic waitCnt(int c);
    while (refCnt != c) @(negedge clk);
  endtask

  task automatic measureHigh(int expHigh, string req);
    int highs = 0;
    waitCnt(0);
    for (int i = 0; i < P; i++) begin
      if (pwmOut) highs++;
      @(negedge clk);
    end
    chk(highs == expHigh, req, highs, expHigh);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(irq == 1'b1, "R1 irq", {31'b0, irq}, 32'd1);
    chk(rdData == 32'h00010000, "R1 rdData", rdData, 32'h00010000);
    chk(shutdownN == 1'b0 && gainOut == 1'b0, "R1 amp", {30'b0, shutdownN, gainOut}, 0);
    measureHigh(P / 2, "R1 threshold");

    // R5 amp on with gain, plus a sample
    wr(32'h00311234);
    chk(gainOut && shutdownN, "R5 amp on", {30'b0, shutdownN, gainOut}, 32'd3);
    chk(rdData[15:0] == 16'h1234 && !irq, "R2 stored", rdData, 32'h00301234);
    // R6 no enable: pins hold
    wr(32'h00005555);
    chk(gainOut && shutdownN, "R6 amp hold", {30'b0, shutdownN, gainOut}, 32'd3);
    wr(32'h00000000);
    chk(rdData[21:20] == 2'b11, "R6 readback", {30'b0, rdData[21:20]}, 32'd3);
    // R3 ready returns at the wrap
    waitCnt(0);
    chk(irq == 1'b1, "R3 ready at wrap", {31'b0, irq}, 32'd1);

    // R4 / R7 extremes, repeated without new writes
    wr(32'h00007FFF);
    measureHigh(thrOf(32'h7FFF), "R4 max");
    measureHigh(P - 1, "R7 max repeat");
    measureHigh(P - 1, "R7 max repeat2");
    wr(32'h00008000);
    measureHigh(thrOf(32'h8000), "R4 min");
    measureHigh(0, "R7 min repeat");
    wr(32'h0000C000);
    measureHigh(thrOf(32'hC000), "R4 quarter");

    // R9 unused read bits stay zero
    wr(32'hFFCE4321);
    chk((rdData & 32'hFFCE0000) == 0, "R9 zero bits", rdData & 32'hFFCE0000, 0);
    chk(gainOut && shutdownN, "R6 amp hold 2", {30'b0, shutdownN, gainOut}, 32'd3);

    // R8 write on the last clock of a period
    wr(32'h00007000);
    waitCnt(P - 1);
    wr(32'h00008000);
    chk(irq == 1'b0, "R8 ready stays low", {31'b0, irq}, 0);
    chk(rdData[15:0] == 16'h8000, "R8 new pending", {16'b0, rdData[15:0]}, 32'h8000);
    measureHigh(thrOf(32'h7000), "R8 old sample plays");
    chk(irq == 1'b1, "R8 ready at next wrap", {31'b0, irq}, 32'd1);
    measureHigh(0, "R8 new sample plays");

    // R5 amp off
    wr(32'h00010000);
    chk(!gainOut && !shutdownN, "R5 amp off", {30'b0, shutdownN, gainOut}, 0);
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule